// File: doc/BRIEF.md
# Bi-Orthogonal Symbol Demodulator with Walsh Correlator Bank

The block turns a stream of chip-rate, carrier-corrected samples into data bits. It uses bi-orthogonal keying, where each symbol spans eight chips. Each channel (I and Q) has its own bank of eight integrate-and-dump correlators. Each correlator is matched to one row of the length-8 Walsh set. Every valid chip is multiplied by the matching code chip and added to a running sum. When the symbol's last chip is flagged, the eight sums are dumped and the accumulators start again from zero.

A magnitude comparator then picks the strongest correlator in each bank. The winner's row number gives three bits, and its sign gives a fourth. This four-bit group is the channel's nibble. The nibbles are rotated to match a quarter-turn phase reference that is loaded at handover. A small state machine then shifts the bits out one per cycle, with a valid flag.

In binary mode only the I bank runs, and each symbol carries four bits. In quadrature mode both banks run, and each symbol carries eight bits.

Top module: `bok_symbol_demod`

The serializer state machine has three states:
- `SER_IDLE` waits for a decision.
- `SER_I_NIB` sends the I nibble.
- `SER_Q_NIB` sends the Q nibble.

Its transitions are:
- `SER_IDLE`→`SER_I_NIB` on a decision.
- `SER_I_NIB`→`SER_Q_NIB` after four bits in quadrature mode.
- `SER_I_NIB`→`SER_IDLE` after four bits in binary mode with no new decision.
- `SER_I_NIB`→`SER_I_NIB` (reload) after four bits in binary mode when a new decision is waiting.
- `SER_Q_NIB`→`SER_IDLE` after four bits with no new decision.
- `SER_Q_NIB`→`SER_I_NIB` (reload) after four bits when a new decision is waiting.

## Requirements
- R1: Code chip c of row r is -1 when popcount(r AND c) is odd, and +1 otherwise. Each correlator adds sample × code chip over the eight chips of a symbol, taken at chip_vld. The chip position counts valid chips since the last sym_last. The sum is dumped on the chip flagged by sym_last, and the accumulator is cleared.
- R2: Per channel, the correlator with the largest absolute sum wins, and a tie goes to the lowest row. The nibble is {row[2:0], s}, where s=1 only when the winning sum is negative. A zero sum gives s=0.
- R3: With quad_mode=1, each symbol sends eight bits, MSB first: the corrected I nibble, then the corrected Q nibble.
- R4: With quad_mode=0, each symbol sends four bits, the corrected I nibble only. chip_q has no effect on the output.
- R5: In quadrature mode, ref_phase k corrects the raw nibbles Ir and Qr as follows (~s means the sign bit is inverted):
  - k=0 gives (I,Q)=(Ir,Qr).
  - k=1 gives (Qr, Ir with ~s).
  - k=2 gives (Ir with ~s, Qr with ~s).
  - k=3 gives (Qr with ~s, Ir).
- R6: In binary mode, the sign bit is inverted when ref_phase[1]=1, and ref_phase[0] has no effect.
- R7: ref_phase is captured when ref_load is high. It applies to every symbol whose decision is made after the capture. It resets to 0.
- R8: bit_vld first rises two rising edges after the edge that takes the last chip of a symbol.
- R9: Back-to-back symbols stream out with no bit lost. Cycles with chip_vld low stall the accumulation without corrupting it.
- R10: During and after reset, bit_vld=0 and bit_out=0. Whenever bit_vld=0, bit_out=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_vld | input | 1 | A chip sample is present this cycle |
| sym_last | input | 1 | The present chip is the last of its symbol |
| chip_i | input | SAMP_W | Signed derotated I sample |
| chip_q | input | SAMP_W | Signed derotated Q sample |
| quad_mode | input | 1 | 1 = both banks (8 bits/symbol), 0 = binary (4 bits/symbol) |
| ref_load | input | 1 | Capture ref_phase |
| ref_phase | input | 2 | Absolute phase reference in quarter turns |
| bit_out | output | 1 | Serial data bit |
| bit_vld | output | 1 | bit_out carries a data bit |

## Verification
The assertions assume three things about the inputs:
- sym_last comes only on the eighth valid chip of a symbol.
- quad_mode changes only while no bits are being sent.
- ref_load is not pulsed between a symbol's last chip and its first bit.

The bench drives every symbol through a task that emits exactly eight valid chips with sym_last on the last one. It changes mode only at the start of a scenario, after the output has drained, and it pulses ref_load only while chip_vld is low and the previous decision has already been loaded.

// File: rtl/bok_demod_pkg.sv
package bok_demod_pkg;

    // serializer states
    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_I_NIB = 2'd1,
        SER_Q_NIB = 2'd2
    } ser_state_t;

    // phase reference in quarter turns
    typedef enum logic [1:0] {
        ROT_0   = 2'd0,
        ROT_90  = 2'd1,
        ROT_180 = 2'd2,
        ROT_270 = 2'd3
    } rot_t;

endpackage

// File: rtl/bok_corr_bank.sv
module bok_corr_bank #(
    parameter int SAMP_W   = 8,
    parameter int NUM_CORR = 8,
    parameter int IDX_W    = $clog2(NUM_CORR),
    parameter int ACC_W    = SAMP_W + IDX_W + 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               acc_en,
    input  logic                               dump_en,
    input  logic [IDX_W-1:0]                   chip_idx,
    input  logic signed [SAMP_W-1:0]           samp,
    output logic [NUM_CORR-1:0][ACC_W-1:0]     dump_sum
);

    localparam int EXT_W = ACC_W - SAMP_W;

    logic signed [ACC_W-1:0] samp_x;
    assign samp_x = $signed({{EXT_W{samp[SAMP_W-1]}}, samp});

    for (genvar k = 0; k < NUM_CORR; k++) begin : g_corr
        localparam logic [IDX_W-1:0] ROW = IDX_W'(k);

        logic signed [ACC_W-1:0] acc_q;
        logic signed [ACC_W-1:0] dump_q;
        logic signed [ACC_W-1:0] term;
        logic signed [ACC_W-1:0] acc_nx;

        always_comb begin
            term   = (^(ROW & chip_idx)) ? -samp_x : samp_x;
            acc_nx = acc_q + term;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q  <= '0;
                dump_q <= '0;
            end else if (acc_en) begin
                if (dump_en) begin
                    dump_q <= acc_nx;
                    acc_q  <= '0;
                end else begin
                    acc_q  <= acc_nx;
                end
            end
        end

        assign dump_sum[k] = dump_q;
    end

endmodule

// File: rtl/bok_max_pick.sv
module bok_max_pick #(
    parameter int NUM_CORR = 8,
    parameter int IDX_W    = $clog2(NUM_CORR),
    parameter int ACC_W    = 12
) (
    input  logic [NUM_CORR-1:0][ACC_W-1:0] sums,
    output logic [IDX_W:0]                 nibble
);

    logic [ACC_W-1:0] best_mag;
    logic [IDX_W-1:0] best_idx;
    logic             best_neg;
    logic [ACC_W-1:0] cur_mag;

    always_comb begin
        best_mag = '0;
        best_idx = '0;
        best_neg = 1'b0;
        cur_mag  = '0;
        for (int i = 0; i < NUM_CORR; i++) begin
            cur_mag = sums[i][ACC_W-1] ? (~sums[i] + 1'b1) : sums[i];
            // strict compare keeps the lowest index on equal magnitudes
            if (cur_mag > best_mag) begin
                best_mag = cur_mag;
                best_idx = IDX_W'(i);
                best_neg = sums[i][ACC_W-1];
            end
        end
        nibble = {best_idx, best_neg};
    end

endmodule

// File: rtl/bok_bit_serializer.sv
module bok_bit_serializer
    import bok_demod_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             quad,
    input  logic [NIB_W-1:0] nib_i,
    input  logic [NIB_W-1:0] nib_q,
    output logic             bit_out,
    output logic             bit_vld
);

    localparam int SH_W  = 2 * NIB_W;
    localparam int CNT_W = (NIB_W > 1) ? $clog2(NIB_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NIB_W - 1);

    ser_state_t       state_q, state_nx;
    logic [SH_W-1:0]  sh_q, sh_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             quad_q, quad_nx;

    // next state and datapath
    always_comb begin
        state_nx = state_q;
        sh_nx    = sh_q;
        cnt_nx   = cnt_q;
        quad_nx  = quad_q;
        unique case (state_q)
            SER_IDLE: begin
                if (load) begin
                    state_nx = SER_I_NIB;
                    sh_nx    = {nib_i, nib_q};
                    cnt_nx   = '0;
                    quad_nx  = quad;
                end
            end
            SER_I_NIB: begin
                sh_nx  = sh_q << 1;
                cnt_nx = cnt_q + 1'b1;
                if (cnt_q == CNT_LAST) begin
                    cnt_nx = '0;
                    if (quad_q) begin
                        state_nx = SER_Q_NIB;
                    end else if (load) begin
                        state_nx = SER_I_NIB;
                        sh_nx    = {nib_i, nib_q};
                        quad_nx  = quad;
                    end else begin
                        state_nx = SER_IDLE;
                    end
                end
            end
            SER_Q_NIB: begin
                sh_nx  = sh_q << 1;
                cnt_nx = cnt_q + 1'b1;
                if (cnt_q == CNT_LAST) begin
                    cnt_nx = '0;
                    if (load) begin
                        state_nx = SER_I_NIB;
                        sh_nx    = {nib_i, nib_q};
                        quad_nx  = quad;
                    end else begin
                        state_nx = SER_IDLE;
                    end
                end
            end
            default: state_nx = SER_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SER_IDLE;
            sh_q    <= '0;
            cnt_q   <= '0;
            quad_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            sh_q    <= sh_nx;
            cnt_q   <= cnt_nx;
            quad_q  <= quad_nx;
        end
    end

    // outputs
    always_comb begin
        bit_vld = (state_q != SER_IDLE);
        bit_out = bit_vld & sh_q[SH_W-1];
    end

endmodule

// File: rtl/bok_symbol_demod.sv
module bok_symbol_demod
    import bok_demod_pkg::*;
#(
    parameter int SAMP_W   = 8,
    parameter int NUM_CORR = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     chip_vld,
    input  logic                     sym_last,
    input  logic signed [SAMP_W-1:0] chip_i,
    input  logic signed [SAMP_W-1:0] chip_q,
    input  logic                     quad_mode,
    input  logic                     ref_load,
    input  logic [1:0]               ref_phase,
    output logic                     bit_out,
    output logic                     bit_vld
);

    localparam int IDX_W = $clog2(NUM_CORR);
    localparam int ACC_W = SAMP_W + IDX_W + 1;
    localparam int NIB_W = IDX_W + 1;

    logic [IDX_W-1:0] chip_idx_q;
    logic             dump_vld_q;
    rot_t             rot_q;

    logic [NUM_CORR-1:0][ACC_W-1:0] sum_i, sum_q;
    logic [NIB_W-1:0] raw_i, raw_q;
    logic [NIB_W-1:0] fix_i, fix_q;

    function automatic logic [NIB_W-1:0] flip_sign(input logic [NIB_W-1:0] n);
        return {n[NIB_W-1:1], ~n[0]};
    endfunction

    // chip position within the symbol, phase reference and dump strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chip_idx_q <= '0;
            dump_vld_q <= 1'b0;
            rot_q      <= ROT_0;
        end else begin
            dump_vld_q <= chip_vld & sym_last;
            if (chip_vld) begin
                chip_idx_q <= sym_last ? '0 : chip_idx_q + 1'b1;
            end
            if (ref_load) begin
                rot_q <= rot_t'(ref_phase);
            end
        end
    end

    bok_corr_bank #(
        .SAMP_W(SAMP_W), .NUM_CORR(NUM_CORR), .IDX_W(IDX_W), .ACC_W(ACC_W)
    ) u_bank_i (
        .clk(clk), .rst_n(rst_n), .acc_en(chip_vld), .dump_en(sym_last),
        .chip_idx(chip_idx_q), .samp(chip_i), .dump_sum(sum_i)
    );

    bok_corr_bank #(
        .SAMP_W(SAMP_W), .NUM_CORR(NUM_CORR), .IDX_W(IDX_W), .ACC_W(ACC_W)
    ) u_bank_q (
        .clk(clk), .rst_n(rst_n), .acc_en(chip_vld & quad_mode), .dump_en(sym_last),
        .chip_idx(chip_idx_q), .samp(chip_q), .dump_sum(sum_q)
    );

    bok_max_pick #(.NUM_CORR(NUM_CORR), .IDX_W(IDX_W), .ACC_W(ACC_W)) u_pick_i (
        .sums(sum_i), .nibble(raw_i)
    );

    bok_max_pick #(.NUM_CORR(NUM_CORR), .IDX_W(IDX_W), .ACC_W(ACC_W)) u_pick_q (
        .sums(sum_q), .nibble(raw_q)
    );

    // absolute phase correction of the decided nibbles
    always_comb begin
        fix_i = raw_i;
        fix_q = raw_q;
        if (!quad_mode) begin
            fix_i = rot_q[1] ? flip_sign(raw_i) : raw_i;
            fix_q = '0;
        end else begin
            unique case (rot_q)
                ROT_0:   begin fix_i = raw_i;            fix_q = raw_q;            end
                ROT_90:  begin fix_i = raw_q;            fix_q = flip_sign(raw_i); end
                ROT_180: begin fix_i = flip_sign(raw_i); fix_q = flip_sign(raw_q); end
                ROT_270: begin fix_i = flip_sign(raw_q); fix_q = raw_i;            end
                default: begin fix_i = raw_i;            fix_q = raw_q;            end
            endcase
        end
    end

    bok_bit_serializer #(.NIB_W(NIB_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .load(dump_vld_q), .quad(quad_mode),
        .nib_i(fix_i), .nib_q(fix_q), .bit_out(bit_out), .bit_vld(bit_vld)
    );

endmodule

// File: rtl/bok_symbol_demod_chk.sv
module bok_symbol_demod_chk (
    input logic clk,
    input logic rst_n,
    input logic chip_vld,
    input logic sym_last,
    input logic quad_mode,
    input logic bit_out,
    input logic bit_vld
);

    logic [3:0] chip_cnt;
    logic [2:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chip_cnt <= '0;
            run_len  <= '0;
        end else begin
            if (chip_vld) chip_cnt <= sym_last ? 4'd0 : chip_cnt + 4'd1;
            run_len <= bit_vld ? run_len + 3'd1 : 3'd0;
        end
    end

    AST_SYM_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_vld && sym_last) |-> (chip_cnt == 4'd7)); // R1

    AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_vld && sym_last) |-> ##2 bit_vld); // R8

    AST_QUAD_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bit_vld) && quad_mode) |-> (run_len == 3'd0)); // R3

    AST_BIN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bit_vld) && !quad_mode) |-> (run_len[1:0] == 2'd0)); // R4

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> $stable(quad_mode)); // R9

    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |-> !bit_out); // R10

endmodule

bind bok_symbol_demod bok_symbol_demod_chk u_chk (
    .clk(clk), .rst_n(rst_n), .chip_vld(chip_vld), .sym_last(sym_last),
    .quad_mode(quad_mode), .bit_out(bit_out), .bit_vld(bit_vld)
);

// File: tb/tb_bok_symbol_demod.sv
module tb_bok_symbol_demod;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             chip_vld;
    logic             sym_last;
    logic signed [7:0] chip_i;
    logic signed [7:0] chip_q;
    logic             quad_mode;
    logic             ref_load;
    logic [1:0]       ref_phase;
    logic             bit_out;
    logic             bit_vld;

    always #4 clk = ~clk;

    bok_symbol_demod dut (
        .clk(clk), .rst_n(rst_n), .chip_vld(chip_vld), .sym_last(sym_last),
        .chip_i(chip_i), .chip_q(chip_q), .quad_mode(quad_mode),
        .ref_load(ref_load), .ref_phase(ref_phase),
        .bit_out(bit_out), .bit_vld(bit_vld)
    );

    int   n_tests = 0;
    int   n_fail  = 0;
    logic got   [0:1023];
    logic exp_b [0:1023];
    int   got_n = 0;
    int   exp_n = 0;

    always @(negedge clk) begin
        if (rst_n === 1'b1 && bit_vld === 1'b1) begin
            if (got_n < 1024) got[got_n] = bit_out;
            got_n = got_n + 1;
        end
    end

    function automatic int wal(int r, int c);
        return ($countones(r & c) % 2 == 1) ? -1 : 1;
    endfunction

    function automatic logic [7:0] exp_byte(int ri, bit ni, int rq, bit nq, bit quad, int ph);
        logic [3:0] a, b, ci, cq;
        a = {ri[2:0], ni};
        b = {rq[2:0], nq};
        if (!quad) begin
            ci = ph[1] ? {a[3:1], ~a[0]} : a;
            cq = 4'd0;
        end else begin
            case (ph)
                0:       begin ci = a;               cq = b;               end
                1:       begin ci = b;               cq = {a[3:1], ~a[0]}; end
                2:       begin ci = {a[3:1], ~a[0]}; cq = {b[3:1], ~b[0]}; end
                default: begin ci = {b[3:1], ~b[0]}; cq = a;               end
            endcase
        end
        return {ci, cq};
    endfunction

    task automatic push_exp(logic [7:0] v, bit quad);
        int nb = quad ? 8 : 4;
        for (int k = 0; k < nb; k++) begin
            exp_b[exp_n] = v[7-k];
            exp_n = exp_n + 1;
        end
    endtask

    task automatic send_chip(int si, int sq, bit last);
        @(negedge clk);
        chip_vld = 1'b1;
        chip_i   = si[7:0];
        chip_q   = sq[7:0];
        sym_last = last;
    endtask

    task automatic go_idle(int n);
        @(negedge clk);
        chip_vld = 1'b0;
        sym_last = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic send_sym(int ri, bit ni, int ai, int rq, bit nq, int aq, bit stall);
        for (int c = 0; c < 8; c++) begin
            int si, sq;
            si = ai * (ni ? -1 : 1) * wal(ri, c) + ((c * 5) % 3) - 1;
            sq = aq * (nq ? -1 : 1) * wal(rq, c) + ((c * 7) % 3) - 1;
            send_chip(si, sq, c == 7);
            if (stall && (c == 2 || c == 5)) go_idle(c == 2 ? 1 : 3);
        end
    endtask

    task automatic set_ref(int ph);
        @(negedge clk);
        chip_vld  = 1'b0;
        sym_last  = 1'b0;
        ref_load  = 1'b1;
        ref_phase = ph[1:0];
        @(negedge clk);
        ref_load  = 1'b0;
    endtask

    task automatic begin_case(bit quad);
        go_idle(14);
        quad_mode = quad;
        @(posedge clk);
        got_n = 0;
        exp_n = 0;
    endtask

    task automatic finish_case(string tag);
        int bad;
        go_idle(16);
        n_tests++;
        if (got_n != exp_n) begin
            n_fail++;
            $display("FAIL %s: bit count got %0d expected %0d", tag, got_n, exp_n);
        end
        bad = -1;
        for (int k = 0; k < exp_n && k < got_n; k++)
            if (bad < 0 && got[k] !== exp_b[k]) bad = k;
        n_tests++;
        if (bad >= 0) begin
            n_fail++;
            $display("FAIL %s: bit %0d got %b expected %b", tag, bad, got[bad], exp_b[bad]);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        n_tests++;
        if (bit_vld !== 1'b0 || bit_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R10: after reset vld/out got %b%b expected 00", bit_vld, bit_out);
        end
    endtask

    // R1 R2 R4 R9: binary sweep of every row and sign, strong Q interference
    task automatic t_binary_sweep();
        begin_case(1'b0);
        set_ref(0);
        for (int r = 0; r < 8; r++)
            for (int n = 0; n < 2; n++) begin
                send_sym(r, n[0], 60, 7 - r, ~n[0], 100, 1'b0);
                push_exp(exp_byte(r, n[0], 0, 1'b0, 1'b0, 0), 1'b0);
            end
        finish_case("R4_binary_sweep");
    endtask

    // R3 R5 R7: quadrature, each phase reference
    task automatic t_quad_phases();
        begin_case(1'b1);
        for (int ph = 0; ph < 4; ph++) begin
            set_ref(ph);
            for (int s = 0; s < 3; s++) begin
                int ri = (ph * 3 + s) % 8;
                int rq = (ph + 5 * s + 2) % 8;
                bit ni = s[0];
                bit nq = ph[0] ^ s[1];
                send_sym(ri, ni, 50, rq, nq, 45, 1'b0);
                push_exp(exp_byte(ri, ni, rq, nq, 1'b1, ph), 1'b1);
            end
        end
        finish_case("R5_quad_phase");
    endtask

    // R6: binary phase reference, bit 0 ignored
    task automatic t_binary_phase();
        begin_case(1'b0);
        for (int ph = 1; ph < 4; ph++) begin
            set_ref(ph);
            send_sym(ph + 2, 1'b0, 70, 0, 1'b0, 0, 1'b0);
            push_exp(exp_byte(ph + 2, 1'b0, 0, 1'b0, 1'b0, ph), 1'b0);
            send_sym(ph, 1'b1, 70, 0, 1'b0, 0, 1'b0);
            push_exp(exp_byte(ph, 1'b1, 0, 1'b0, 1'b0, ph), 1'b0);
        end
        finish_case("R6_binary_phase");
    endtask

    // R2: equal magnitudes pick the lowest row
    task automatic t_tie();
        begin_case(1'b1);
        set_ref(0);
        for (int c = 0; c < 8; c++)
            send_chip(30 * (wal(1, c) + wal(2, c)), -30 * (wal(3, c) + wal(6, c)), c == 7);
        push_exp(exp_byte(1, 1'b0, 3, 1'b1, 1'b1, 0), 1'b1);
        finish_case("R2_tie");
    endtask

    // R2: all-zero symbol gives row 0 and positive sign
    task automatic t_zero();
        begin_case(1'b1);
        for (int c = 0; c < 8; c++) send_chip(0, 0, c == 7);
        push_exp(8'h00, 1'b1);
        finish_case("R2_zero");
    endtask

    // R1: full-scale samples do not overflow the sums
    task automatic t_fullscale();
        begin_case(1'b1);
        for (int c = 0; c < 8; c++) send_chip(-128, 127 * wal(7, c), c == 7);
        push_exp(exp_byte(0, 1'b1, 7, 1'b0, 1'b1, 0), 1'b1);
        finish_case("R1_fullscale");
    endtask

    // R9: stalls inside symbols, back-to-back quad stream
    task automatic t_stall();
        begin_case(1'b1);
        for (int s = 0; s < 4; s++) begin
            send_sym(s * 2 + 1, s[0], 40, 6 - s, ~s[0], 55, s[0] == 1'b0);
            push_exp(exp_byte(s * 2 + 1, s[0], 6 - s, ~s[0], 1'b1, 0), 1'b1);
        end
        finish_case("R9_stall");
    endtask

    // R8: first bit two edges after the last chip
    task automatic t_latency();
        bit ok;
        begin_case(1'b1);
        for (int c = 0; c < 8; c++) send_chip(60 * wal(5, c), 60 * wal(2, c), c == 7);
        go_idle(1);
        ok = (bit_vld === 1'b0);
        @(negedge clk);
        ok = ok && (bit_vld === 1'b1) && (bit_out === 1'b1);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R8: first bit timing got vld=%b out=%b expected vld=1 out=1", bit_vld, bit_out);
        end
        push_exp(exp_byte(5, 1'b0, 2, 1'b0, 1'b1, 0), 1'b1);
        finish_case("R8_latency");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; chip_vld = 1'b0; sym_last = 1'b0;
        chip_i = '0; chip_q = '0; quad_mode = 1'b0;
        ref_load = 1'b0; ref_phase = 2'd0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_binary_sweep();
        t_quad_phases();
        t_binary_phase();
        t_tie();
        t_zero();
        t_fullscale();
        t_stall();
        t_latency();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule